// File: doc/BRIEF.md
# Packed Byte Lane Arithmetic Unit

This functional unit takes two 32-bit words and treats each as four unsigned 8-bit lanes. One opcode selects a single operation, and that operation is applied to all four lane pairs at the same time. Each lane is computed on its own, and no carry or borrow crosses from one lane into the next. The result word is registered, so it appears one clock after the operands are presented.

The available operations are wrapping add, wrapping subtract, unsigned minimum, unsigned maximum, rounding average, and a clamped add. The clamped add treats the first operand's lanes as unsigned pixel values and the second operand's lanes as signed residuals, and limits each lane sum to the range 0 to 255. The average and the clamped add are the two operations used most in motion-compensated video reconstruction loops. Together they replace a per-pixel sequence of add, shift, compare and select with one operation per word.

Top module: `simd_byte_alu`

## Requirements
- R1: The four 8-bit lanes (lane n occupies bits 8n+7 to 8n) are independent: a carry or borrow in one lane never changes any other lane.
- R2: Opcode 0 gives each lane (a + b) modulo 256.
- R3: Opcode 1 gives each lane (a - b) modulo 256.
- R4: Opcode 2 gives each lane the unsigned minimum of a and b.
- R5: Opcode 3 gives each lane the unsigned maximum of a and b.
- R6: Opcode 4 gives each lane (a + b + 1) / 2 rounded down, without overflow, so 255 and 255 give 255.
- R7: Opcode 5 adds unsigned lane a to lane b read as signed two's complement (-128 to 127), and clamps the sum to 0 if negative and to 255 if above 255.
- R8: Opcodes 6 and 7 produce a zero result word.
- R9: The result and outValid appear exactly one clock after a cycle with inValid high, and outValid is low one clock after a cycle with inValid low.
- R10: While inValid is low, the result word keeps its previous value whatever the operands and opcode are.
- R11: After reset, outValid is low and the result word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| opSel | input | 3 | Operation select |
| opA | input | 32 | First operand, four unsigned lanes |
| opB | input | 32 | Second operand, four lanes (signed for opcode 5) |
| outValid | output | 1 | Result word is valid |
| result | output | 32 | Registered lane results |

## Verification
The design has no state across operations other than the result register and the valid flag. A fault therefore shows at the ports on the first clock after the operation that exposes it. A decode or lane fault appears as a wrong byte in the result word one cycle after the operands, and only in the lanes whose values reach the faulty path. This makes operands with mixed carry, borrow and sign patterns across lanes the important stimulus. A fault in the load or valid register shows as a result that changes while inValid is low, or as outValid that does not follow inValid one cycle later.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MIN  = 3'd2,
    OP_MAX  = 3'd3,
    OP_AVG  = 3'd4,
    OP_CLIP = 3'd5
  } laneOp_e;

  typedef struct packed {
    logic load;
    logic selAdd;
    logic selSub;
    logic selMin;
    logic selMax;
    logic selAvg;
    logic selClip;
  } laneStrobe_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  output laneStrobe_t     strobe,
  output logic            outValid
);
  always_comb begin
    strobe         = '0;
    strobe.load    = inValid;
    strobe.selAdd  = (opSel == OP_ADD);
    strobe.selSub  = (opSel == OP_SUB);
    strobe.selMin  = (opSel == OP_MIN);
    strobe.selMax  = (opSel == OP_MAX);
    strobe.selAvg  = (opSel == OP_AVG);
    strobe.selClip = (opSel == OP_CLIP);
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
#(
  parameter int W = 8
) (
  input  laneStrobe_t  strobe,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  localparam logic [W-1:0] LANE_MAX = {W{1'b1}};

  logic [W-1:0]          sumW, diffW, minW, maxW, avgW, clipW;
  logic signed [W+1:0]   clipSum;

  always_comb begin
    sumW  = a + b;
    diffW = a - b;
    minW  = (a < b) ? a : b;
    maxW  = (a < b) ? b : a;
    // floor((a+b+1)/2) split so no bit is lost: halves plus the rounding bit
    avgW  = (a >> 1) + (b >> 1) + {{(W-1){1'b0}}, (a[0] | b[0])};
    clipSum = $signed({2'b00, a}) + $signed({{2{b[W-1]}}, b});
    if (clipSum < 0)
      clipW = '0;
    else if (clipSum > $signed({2'b00, LANE_MAX}))
      clipW = LANE_MAX;
    else
      clipW = clipSum[W-1:0];

    y = ({W{strobe.selAdd}}  & sumW)
      | ({W{strobe.selSub}}  & diffW)
      | ({W{strobe.selMin}}  & minW)
      | ({W{strobe.selMax}}  & maxW)
      | ({W{strobe.selAvg}}  & avgW)
      | ({W{strobe.selClip}} & clipW);
  end
endmodule

// File: rtl/simd_datapath.sv
module simd_datapath
  import simd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  laneStrobe_t             strobe,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  output logic [LANES*LANE_W-1:0] result
);
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] laneOut;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_lane #(.W(LANE_W)) u_lane (
      .strobe (strobe),
      .a      (opA[g*LANE_W +: LANE_W]),
      .b      (opB[g*LANE_W +: LANE_W]),
      .y      (laneOut[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)            result <= '0;
    else if (strobe.load) result <= laneOut;
  end
endmodule

// File: rtl/simd_byte_alu.sv
module simd_byte_alu
  import simd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [OP_W-1:0]         opSel,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  output logic                    outValid,
  output logic [LANES*LANE_W-1:0] result
);
  laneStrobe_t strobe;

  simd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .strobe   (strobe),
    .outValid (outValid)
  );

  simd_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result)
  );
endmodule

// File: rtl/simd_byte_alu_chk.sv
module simd_byte_alu_chk
  import simd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [OP_W-1:0]         opSel,
  input logic [LANES*LANE_W-1:0] opA,
  input logic [LANES*LANE_W-1:0] opB,
  input logic                    outValid,
  input logic [LANES*LANE_W-1:0] result
);
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));
  a_r8_unknown_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel > 3'd5) |=> (result == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r4_min_bound: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == OP_MIN) |=>
        (result[g*LANE_W +: LANE_W] <= $past(opA[g*LANE_W +: LANE_W])) &&
        (result[g*LANE_W +: LANE_W] <= $past(opB[g*LANE_W +: LANE_W])));
    a_r5_max_bound: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == OP_MAX) |=>
        (result[g*LANE_W +: LANE_W] >= $past(opA[g*LANE_W +: LANE_W])) &&
        (result[g*LANE_W +: LANE_W] >= $past(opB[g*LANE_W +: LANE_W])));
    a_r6_avg_between: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opSel == OP_AVG && opA[g*LANE_W +: LANE_W] <= opB[g*LANE_W +: LANE_W]) |=>
        (result[g*LANE_W +: LANE_W] >= $past(opA[g*LANE_W +: LANE_W])) &&
        (result[g*LANE_W +: LANE_W] <= $past(opB[g*LANE_W +: LANE_W])));
  end
endmodule

bind simd_byte_alu simd_byte_alu_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opSel    (opSel),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result)
);

// File: tb/simd_byte_alu_tb.sv
module simd_byte_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_byte_alu u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = '0;
    for (int l = 0; l < 4; l++) begin
      int x, y, s;
      x = int'(a[l*8 +: 8]);
      y = int'(b[l*8 +: 8]);
      case (op)
        3'd0: s = (x + y) % 256;
        3'd1: s = (x - y + 256) % 256;
        3'd2: s = (x < y) ? x : y;
        3'd3: s = (x > y) ? x : y;
        3'd4: s = (x + y + 1) / 2;
        3'd5: begin
          s = x + ((y > 127) ? y - 256 : y);
          if (s < 0) s = 0;
          if (s > 255) s = 255;
        end
        default: s = 0;
      endcase
      r[l*8 +: 8] = 8'(s);
    end
    return r;
  endfunction

  function automatic string tagOf(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge (one register on the path)
  task automatic issue(input string tag, input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, outValid}, 32'd1);
    check(tag, result, model(op, a, b));
    inValid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R11 valid", {31'd0, outValid}, 32'd0);
    check("R11 result", result, 32'd0);
    rstN = 1'b1;

    // directed corners
    issue("R1", 3'd0, 32'h01_01_01_FF, 32'h00_00_00_01);
    issue("R1", 3'd1, 32'h05_05_05_00, 32'h00_00_00_01);
    issue("R2", 3'd0, 32'h80_FF_7F_10, 32'h80_FF_01_20);
    issue("R3", 3'd1, 32'h00_10_FF_33, 32'hFF_20_00_33);
    issue("R4", 3'd2, 32'h00_FF_80_7F, 32'hFF_00_7F_80);
    issue("R5", 3'd3, 32'h00_FF_80_7F, 32'hFF_00_7F_80);
    issue("R6", 3'd4, 32'hFF_00_01_FE, 32'hFF_00_02_FF);
    issue("R7", 3'd5, 32'hF0_05_80_FF, 32'h7F_80_80_01);
    issue("R7", 3'd5, 32'h10_FF_00_80, 32'hFF_81_7F_00);
    issue("R8", 3'd6, 32'hFFFF_FFFF, 32'h1234_5678);
    issue("R8", 3'd7, 32'hA5A5_A5A5, 32'h5A5A_5A5A);

    // R10: inputs change with inValid low, result must not move
    held = result;
    @(negedge clk);
    inValid = 1'b0; opSel = 3'd0; opA = 32'h1111_1111; opB = 32'h2222_2222;
    @(negedge clk);
    check("R9 drop", {31'd0, outValid}, 32'd0);
    check("R10", result, held);
    @(negedge clk);
    opSel = 3'd3; opA = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R10", result, held);

    // R9: back-to-back random stream, one result per cycle
    begin
      logic [31:0] expPrev;
      string tagPrev;
      bit havePrev;
      havePrev = 0;
      expPrev = '0;
      tagPrev = "";
      for (int i = 0; i < 400; i++) begin
        logic [2:0] op;
        logic [31:0] a, b;
        bit v;
        op = 3'($urandom % 8);
        a = $urandom;
        b = $urandom;
        v = ($urandom % 4) != 0;
        @(negedge clk);
        if (havePrev) begin
          check({tagPrev, " stream"}, result, expPrev);
          check("R9 stream valid", {31'd0, outValid}, 32'd1);
        end else if (i > 0) begin
          check("R10 stream hold", result, expPrev);
          check("R9 stream idle", {31'd0, outValid}, 32'd0);
        end
        inValid = v; opSel = op; opA = a; opB = b;
        if (v) begin
          expPrev = model(op, a, b);
          tagPrev = tagOf(op);
        end
        havePrev = v;
      end
      @(negedge clk);
      if (havePrev) check({tagPrev, " stream"}, result, expPrev);
      inValid = 1'b0;
    end

    // R11: reset in mid-run clears the state
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R11 rerun valid", {31'd0, outValid}, 32'd0);
    check("R11 rerun result", result, 32'd0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule